// File: doc/BRIEF.md
# Floating-Point Vector Compare Unit

This block walks through the elements of a floating-point vector register group and produces one result bit per element, which it packs into a destination mask. Each element of the primary source is compared against either the matching element of a second source (vector-vector form) or a single scalar (vector-scalar form). Elements are 16, 32 or 64 bits wide. Seven predicates are available: equal, not-equal, less-than, less-or-equal, greater-than, greater-or-equal and ordered.

A run begins with a one-cycle `start_i`. The unit then steps through element indices 0 to vlmax-1 at one index per cycle. It presents each index on `rd_idx_o` and reads both operands back on the same cycle. Active elements (index below vl, and either unmasked or enabled by their v0 bit) receive the predicate result. Masked-off elements keep their prior destination bit. Elements in the tail, from vl up to vlmax-1, are forced to zero. An invalid-operation flag collects NaN exceptions across runs until it is cleared.

Top module: `vfcmp_unit`

## Requirements
- R1: In vector-vector form, result bit i is pred(a, b), where a is the primary element i and b is the second-source element i. Predicate codes on `pred_i` are: 0 equal, 1 not-equal, 2 less-than, 3 less-or-equal, 4 greater-than, 5 greater-or-equal, 6 ordered.
- R2: In vector-scalar form (`scalar_form_i`=1), b is `scalar_op_i` truncated to the element width. Operand bits above the element width never affect a result or the flag.
- R3: +0 and -0 compare equal. When either operand is NaN, every predicate yields 0 except not-equal, which yields 1.
- R4: Ordered yields 1 exactly when neither operand is NaN.
- R5: Equal, not-equal and ordered raise the invalid flag only when an operand of an active element is a signaling NaN (exponent all ones, nonzero fraction, fraction MSB 0).
- R6: Less-than, less-or-equal, greater-than and greater-or-equal raise the invalid flag when an operand of an active element is any NaN.
- R7: With `vm_i`=0, an element whose `v0_i` bit is 0 keeps its destination bit from `dst_i` and contributes nothing to the flag.
- R8: Bits with index from vl up to vlmax-1 end as 0. Bits at index vlmax and above keep their `dst_i` value.
- R9: One element index is processed per cycle. `done_o` is a single-cycle pulse that rises vlmax+1 clock edges after the edge that accepts `start_i`, or 1 edge after it when vlmax is 0. `busy_o` and `done_o` are never high together.
- R10: `inv_flag_o` is the OR of every exception raised since it was last cleared. It stays set until `flag_clr_i` is asserted for one cycle.
- R11: Element width codes on `ew_i` are 0 for 16-bit, 1 for 32-bit and 2 for 64-bit (IEEE 754 binary16/32/64).
- R12: After reset, `busy_o`, `done_o`, `mask_o` and `inv_flag_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a run; ignored while busy |
| pred_i | input | 3 | Predicate code |
| ew_i | input | 2 | Element width code |
| scalar_form_i | input | 1 | 1 selects the vector-scalar form |
| vm_i | input | 1 | 1 disables v0 masking |
| vl_i | input | $clog2(MAXE+1) | Active vector length |
| vlmax_i | input | $clog2(MAXE+1) | Element count of the group (clamped to MAXE) |
| v0_i | input | MAXE | Mask register v0 |
| dst_i | input | MAXE | Prior destination mask contents |
| scalar_op_i | input | 64 | Scalar operand |
| rd_idx_o | output | $clog2(MAXE) | Element index being read |
| vs2_elem_i | input | 64 | Primary source element at rd_idx_o |
| vs1_elem_i | input | 64 | Second source element at rd_idx_o |
| flag_clr_i | input | 1 | Clears the sticky invalid flag |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mask_o | output | MAXE | Destination mask |
| inv_flag_o | output | 1 | Sticky invalid-operation flag |

## Verification
The assertions check the control rules on every cycle. They cover the shape of the done pulse and its exclusion with busy, tail bits becoming zero as the index passes them, masked-off bits staying unchanged across their cycle, and the flag being sticky and cleared on request. The IEEE semantics need the bench's scenarios and its behavioural reference. These are the signed-zero equality, the NaN results per predicate, the quiet versus signaling flag rule, scalar truncation, each element width and the exact completion latency.

// File: rtl/vfcmp_unit.sv
module vfcmp_unit #(
  parameter int MAXE = 64,
  localparam int IW = $clog2(MAXE),
  localparam int VW = $clog2(MAXE + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [2:0]      pred_i,
  input  logic [1:0]      ew_i,
  input  logic            scalar_form_i,
  input  logic            vm_i,
  input  logic [VW-1:0]   vl_i,
  input  logic [VW-1:0]   vlmax_i,
  input  logic [MAXE-1:0] v0_i,
  input  logic [MAXE-1:0] dst_i,
  input  logic [63:0]     scalar_op_i,
  output logic [IW-1:0]   rd_idx_o,
  input  logic [63:0]     vs2_elem_i,
  input  logic [63:0]     vs1_elem_i,
  input  logic            flag_clr_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [MAXE-1:0] mask_o,
  output logic            inv_flag_o
);

  logic [2:0]      pred_q;
  logic [1:0]      ew_q;
  logic            form_q, vm_q;
  logic [VW-1:0]   vl_q, vlmax_q;
  logic [MAXE-1:0] v0_q;
  logic [63:0]     sc_q;
  logic [IW-1:0]   idx;

  function automatic logic [65:0] decode(input logic [63:0] x, input logic [1:0] ew);
    logic s, ex1, mz, q;
    logic [62:0] mag;
    case (ew)
      2'd0: begin s = x[15]; mag = {48'd0, x[14:0]}; ex1 = &x[14:10]; mz = |x[9:0];  q = x[9];  end
      2'd1: begin s = x[31]; mag = {32'd0, x[30:0]}; ex1 = &x[30:23]; mz = |x[22:0]; q = x[22]; end
      default: begin s = x[63]; mag = x[62:0]; ex1 = &x[62:52]; mz = |x[51:0]; q = x[51]; end
    endcase
    return {s, ex1 & mz, ex1 & mz & ~q, mag};
  endfunction

  logic [65:0] da, db;
  logic        unord, both_zero, eq, lt, gt, quiet, res, inv;
  logic        in_body, active;

  assign da = decode(vs2_elem_i, ew_q);
  assign db = decode(form_q ? sc_q : vs1_elem_i, ew_q);

  assign unord     = da[64] | db[64];
  assign both_zero = (da[62:0] == '0) && (db[62:0] == '0);
  assign eq = !unord && (both_zero || (da[65] == db[65] && da[62:0] == db[62:0]));
  assign lt = !unord && !both_zero &&
              ((da[65] && !db[65]) ||
               (!da[65] && !db[65] && da[62:0] < db[62:0]) ||
               (da[65] && db[65] && da[62:0] > db[62:0]));
  assign gt = !unord && !eq && !lt;
  assign quiet = (pred_q == 3'd0) || (pred_q == 3'd1) || (pred_q >= 3'd6);

  always_comb begin
    case (pred_q)
      3'd0: res = eq;
      3'd1: res = !eq;
      3'd2: res = lt;
      3'd3: res = lt | eq;
      3'd4: res = gt;
      3'd5: res = gt | eq;
      3'd6: res = !unord;
      default: res = 1'b0;
    endcase
  end

  assign inv     = quiet ? (da[63] | db[63]) : unord;
  assign in_body = {1'b0, idx} < {1'b0, vl_q};
  assign active  = busy_o && in_body && (vm_q || v0_q[idx]);
  assign rd_idx_o = idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0; done_o <= 1'b0; mask_o <= '0; idx <= '0;
      pred_q <= '0; ew_q <= '0; form_q <= 1'b0; vm_q <= 1'b1;
      vl_q <= '0; vlmax_q <= '0; v0_q <= '0; sc_q <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_o) begin
        pred_q <= pred_i; ew_q <= ew_i; form_q <= scalar_form_i; vm_q <= vm_i;
        vl_q <= vl_i; v0_q <= v0_i; sc_q <= scalar_op_i; mask_o <= dst_i; idx <= '0;
        vlmax_q <= (vlmax_i > VW'(MAXE)) ? VW'(MAXE) : vlmax_i;
        busy_o <= (vlmax_i != '0);
        done_o <= (vlmax_i == '0);
      end else if (busy_o) begin
        if (!in_body) mask_o[idx] <= 1'b0;
        else if (active) mask_o[idx] <= res;
        if (VW'(idx) + VW'(1) >= vlmax_q) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inv_flag_o <= 1'b0;
    else        inv_flag_o <= (inv_flag_o & ~flag_clr_i) | (active & inv);
  end

endmodule

// File: rtl/vfcmp_unit_chk.sv
module vfcmp_unit_chk #(
  parameter int MAXE = 64,
  localparam int IW = $clog2(MAXE),
  localparam int VW = $clog2(MAXE + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy_o,
  input logic            done_o,
  input logic [IW-1:0]   rd_idx_o,
  input logic [MAXE-1:0] mask_o,
  input logic            inv_flag_o,
  input logic            flag_clr_i,
  input logic            vm_q,
  input logic [VW-1:0]   vl_q,
  input logic [MAXE-1:0] v0_q
);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r9_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

  a_r8_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && {1'b0, rd_idx_o} >= {1'b0, vl_q}) |=> !mask_o[$past(rd_idx_o)]);

  a_r7_masked_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !vm_q && !v0_q[rd_idx_o] && {1'b0, rd_idx_o} < {1'b0, vl_q})
      |=> mask_o[$past(rd_idx_o)] == $past(mask_o[rd_idx_o]));

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_flag_o && !flag_clr_i) |=> inv_flag_o);

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_i && !busy_o) |=> !inv_flag_o);

endmodule

bind vfcmp_unit vfcmp_unit_chk #(.MAXE(MAXE)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o),
  .rd_idx_o(rd_idx_o), .mask_o(mask_o), .inv_flag_o(inv_flag_o),
  .flag_clr_i(flag_clr_i), .vm_q(vm_q), .vl_q(vl_q), .v0_q(v0_q)
);

// File: tb/vfcmp_unit_tb_top.sv
`timescale 1ns/1ps
module vfcmp_unit_tb_top;
  localparam int MAXE = 64;
  localparam int IW = $clog2(MAXE);
  localparam int VW = $clog2(MAXE + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic            start_i = 0, scalar_form_i = 0, vm_i = 1, flag_clr_i = 0;
  logic [2:0]      pred_i = 0;
  logic [1:0]      ew_i = 0;
  logic [VW-1:0]   vl_i = 0, vlmax_i = 0;
  logic [MAXE-1:0] v0_i = 0, dst_i = 0;
  logic [63:0]     scalar_op_i = 0;
  logic [IW-1:0]   rd_idx_o;
  logic [63:0]     vs2_elem_i, vs1_elem_i;
  logic            busy_o, done_o, inv_flag_o;
  logic [MAXE-1:0] mask_o;

  logic [63:0] m2 [MAXE];
  logic [63:0] m1 [MAXE];
  assign vs2_elem_i = m2[rd_idx_o];
  assign vs1_elem_i = m1[rd_idx_o];

  vfcmp_unit #(.MAXE(MAXE)) dut_i (.*);

  int checks = 0, failures = 0;
  bit exp_flag = 0;

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int wid(int ew);  return ew == 0 ? 16 : ew == 1 ? 32 : 64; endfunction
  function automatic int ebits(int ew); return ew == 0 ? 5 : ew == 1 ? 8 : 11; endfunction

  function automatic logic [63:0] mk(int ew, int kind);
    int w = wid(ew), e = ebits(ew), m = wid(ew) - ebits(ew) - 1;
    logic [63:0] bias = (64'd1 << (e - 1)) - 1;
    logic [63:0] inf = ((64'd1 << e) - 1) << m;
    logic [63:0] sgn = 64'd1 << (w - 1);
    logic [63:0] v;
    case (kind)
      0: v = 0;
      1: v = sgn;
      2: v = bias << m;
      3: v = (bias + 1) << m;
      4: v = sgn | (bias << m);
      5: v = sgn | ((bias + 1) << m);
      6: v = inf;
      7: v = inf | (64'd1 << (m - 1));
      8: v = inf | 64'd1;
      default: v = sgn | inf;
    endcase
    if (w < 64) v |= 64'hA5A5_A5A5_A5A5_A5A5 & ~((64'd1 << w) - 1);
    return v;
  endfunction

  // returns {result, invalid}
  function automatic logic [1:0] ref_cmp(int pred, int ew, logic [63:0] a, logic [63:0] b);
    int w = wid(ew), e = ebits(ew);
    logic [63:0] la = a << (64 - w), lb = b << (64 - w);
    logic [63:0] msb = 64'h8000_0000_0000_0000;
    logic [63:0] inf = (((64'd1 << e) - 1) << (63 - e));
    logic [63:0] aa = la & ~msb, ab = lb & ~msb;
    bit na = aa > inf, nb = ab > inf;
    bit sa = na && !la[62 - e], sb = nb && !lb[62 - e];
    logic [63:0] ka = aa == 0 ? msb : (la[63] ? ~la : (la | msb));
    logic [63:0] kb = ab == 0 ? msb : (lb[63] ? ~lb : (lb | msb));
    bit un = na || nb;
    bit eq = !un && ka == kb, lt = !un && ka < kb, gt = !un && ka > kb;
    bit r, iv;
    case (pred)
      0: r = eq;  1: r = !eq;  2: r = lt;  3: r = lt || eq;
      4: r = gt;  5: r = gt || eq;  6: r = !un;  default: r = 0;
    endcase
    iv = (pred == 0 || pred == 1 || pred == 6) ? (sa || sb) : un;
    return {r, iv};
  endfunction

  task automatic fill(int ew);
    for (int i = 0; i < MAXE; i++) begin
      m2[i] = mk(ew, i % 10);
      m1[i] = mk(ew, (i * 7 + 3) % 10);
      if (i % 5 == 4)  m1[i] = mk(ew, i % 10);
      if (i % 5 == 2)  m1[i] = mk(ew, 3);
      if (i % 10 == 5) m1[i] = mk(ew, 4);
    end
  endtask

  task automatic run(string tag, bit clr, int pred, int ew, bit form, bit vm, int vl, int vlm,
                     logic [63:0] v0, logic [63:0] dst, logic [63:0] sc);
    logic [63:0] em = dst;
    bit ef = 0, order_ok = 1;
    int cnt = 0;
    logic [1:0] rv;
    for (int i = 0; i < vlm; i++) begin
      if (i >= vl) em[i] = 1'b0;
      else if (vm || v0[i]) begin
        rv = ref_cmp(pred, ew, m2[i], form ? sc : m1[i]);
        em[i] = rv[1];
        ef |= rv[0];
      end
    end
    @(negedge clk);
    if (clr) begin
      flag_clr_i = 1; @(negedge clk); flag_clr_i = 0;
      exp_flag = 0;
    end
    pred_i = 3'(pred); ew_i = 2'(ew); scalar_form_i = form; vm_i = vm;
    vl_i = VW'(vl); vlmax_i = VW'(vlm); v0_i = v0; dst_i = dst; scalar_op_i = sc;
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    cnt = 1;
    while (!done_o && cnt < 200) begin
      if (!busy_o) order_ok = 0;
      @(negedge clk);
      cnt++;
    end
    exp_flag |= ef;
    chk(order_ok && cnt == vlm + 1, {tag, " R9"}, "cycles to done", 64'(cnt), 64'(vlm + 1));
    chk(mask_o == em, tag, "mask", mask_o, em);
    chk(inv_flag_o == exp_flag, tag, "invalid flag", 64'(inv_flag_o), 64'(exp_flag));
    @(negedge clk);
    chk(!done_o, "R9", "done width", 64'(done_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < MAXE; i++) begin m2[i] = 0; m1[i] = 0; end
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!busy_o, "R12", "busy", 64'(busy_o), 0);
    chk(!done_o, "R12", "done", 64'(done_o), 0);
    chk(mask_o == 0, "R12", "mask", mask_o, 0);
    chk(!inv_flag_o, "R12", "flag", 64'(inv_flag_o), 0);
    rst_n = 1;

    // R1 R3 R4 R6: every predicate, vector-vector, 32-bit
    fill(1);
    for (int p = 0; p < 7; p++) run("R1", 1, p, 1, 0, 1, 20, 20, 0, 0, 0);
    run("R4", 1, 6, 1, 0, 1, 30, 30, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    run("R3", 1, 1, 1, 0, 1, 30, 30, 0, 0, 0);

    // R11: other widths
    fill(0);
    run("R11", 1, 3, 0, 0, 1, 30, 30, 0, 0, 0);
    run("R11", 1, 0, 0, 0, 1, 25, 25, 0, 0, 0);
    fill(2);
    run("R11", 1, 2, 2, 0, 1, 30, 30, 0, 0, 0);
    run("R11", 1, 5, 2, 0, 1, 30, 30, 0, 0, 0);

    // R2: scalar form, upper scalar bits garbage
    fill(1);
    run("R2", 1, 4, 1, 1, 1, 20, 20, 0, 0, mk(1, 3));
    run("R2", 1, 1, 1, 1, 1, 20, 20, 0, 0, mk(1, 0) | 64'h1234_5678_0000_0000);

    // R7 R8: masking with tail
    run("R7", 1, 0, 1, 0, 0, 40, 48, 64'h5A5A_F00F_3C3C_1234, 64'hFFFF_0000_FFFF_0000, 0);
    run("R8", 1, 5, 1, 0, 1, 5, 12, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    run("R8", 1, 2, 1, 0, 1, 0, 8, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    run("R9", 1, 0, 1, 0, 1, 0, 0, 0, 64'h0F0F, 0);
    run("R9", 1, 0, 1, 0, 1, 64, 64, 0, 0, 0);

    // R5 R6 R7 R10: flag rules on elements 0 (+0) and 1 (-0)
    run("R5", 1, 0, 1, 1, 1, 2, 2, 0, 0, mk(1, 7));
    chk(!inv_flag_o, "R5", "quiet NaN no flag", 64'(inv_flag_o), 0);
    run("R6", 1, 2, 1, 1, 1, 2, 2, 0, 0, mk(1, 7));
    chk(inv_flag_o, "R6", "signaling pred on quiet NaN", 64'(inv_flag_o), 1);
    run("R10", 0, 0, 1, 1, 1, 2, 2, 0, 0, mk(1, 2));
    chk(inv_flag_o, "R10", "sticky", 64'(inv_flag_o), 1);
    run("R5", 1, 6, 1, 1, 1, 2, 2, 0, 0, mk(1, 8));
    chk(inv_flag_o, "R5", "signaling NaN flags", 64'(inv_flag_o), 1);
    run("R7", 1, 2, 1, 1, 0, 2, 2, 0, 64'h3, mk(1, 8));
    chk(!inv_flag_o, "R7", "masked element no flag", 64'(inv_flag_o), 0);
    @(negedge clk); flag_clr_i = 1; @(negedge clk); flag_clr_i = 0;
    chk(!inv_flag_o, "R10", "cleared", 64'(inv_flag_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule